// File: doc/BRIEF.md
# Conditional Jump Resolver

This block settles one relative jump. It takes a 16-bit jump instruction word, the address of the word that follows it, and the four status flags (overflow V, negative N, zero Z, carry C). It returns two results: the branch target address and a bit that says whether the jump is taken. The target is the following address plus twice the signed 10-bit offset held in the low bits of the word. The taken bit comes from a three-bit condition field that selects a test on the flags. The tests cover zero, carry, sign and the signed order (N against V).

Requests enter on a valid/ready port and results leave on a valid/ready port. By default one register stage sits between them (`REG_OUT = 1`). That stage accepts a new request when it is empty, or when its current result is being taken in the same cycle. This lets it run one request per cycle when the consumer never stalls. When `out_ready` is low and a result is waiting, the stage holds that result unchanged and pushes `in_ready` low. With `REG_OUT = 0` the results are combinational, `out_valid` follows `in_valid`, and `in_ready` follows `out_ready`.

Top module: `jmp_resolve`

## Requirements
- R1: With bits 15:13 = 001 and condition field bits 12:10 = 000, taken is 1 exactly when Z = 0. With field 001, taken is 1 exactly when Z = 1.
- R2: With the jump header, field 010 is taken exactly when C = 0 and field 011 is taken exactly when C = 1.
- R3: With the jump header, field 100 is taken exactly when N = 1.
- R4: With the jump header, field 101 is taken exactly when N equals V, and field 110 is taken exactly when N differs from V.
- R5: With the jump header, field 111 is taken whatever the flags are.
- R6: out_target equals next_pc plus two times the sign-extended value of bits 9:0, wrapped modulo 2^16.
- R7: When bits 15:13 are not 001, out_taken is 0 for every flag and condition value.
- R8: In registered mode, out_valid is 1 in the cycle after an input handshake. While out_valid is 1 and out_ready is 0, out_valid, out_target and out_taken stay unchanged.
- R9: In registered mode, in_ready is 0 exactly when a result is held and out_ready is 0. After reset, out_valid is 0 and in_ready is 1.
- R10: When next_pc is even, out_target is even.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request accepted this cycle when in_valid is also 1 |
| instr_word | input | 16 | Jump instruction word |
| next_pc | input | 16 | Address of the word after the jump |
| flag_v | input | 1 | Overflow flag |
| flag_n | input | 1 | Negative flag |
| flag_z | input | 1 | Zero flag |
| flag_c | input | 1 | Carry flag |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_target | output | 16 | Branch target address |
| out_taken | output | 1 | Jump is taken |

## Verification
Each of the eight condition codes is driven with the flag value that should take the jump and with the flag value that should not. For the N-against-V codes, all four N/V pairs are used, which shows whether the design is testing signed order or only the sign bit. Words with the top three bits different from 001 are driven with the always-taken code and all flags set. This shows whether the format gate works apart from the condition logic. For the target, directed offsets cover the largest positive offset, the most negative offset, and wrap in both directions, so a wrong sign extension or a missing doubling is caught. Random words and random stall lengths check that results stay stable under back-pressure and that two requests sent back to back come out in order.

// File: rtl/jmp_pkg.sv
package jmp_pkg;
  typedef struct packed {
    logic v;
    logic n;
    logic z;
    logic c;
  } jmp_flags_t;

  typedef enum logic [2:0] {
    CC_NZERO  = 3'd0,
    CC_ZERO   = 3'd1,
    CC_NCARRY = 3'd2,
    CC_CARRY  = 3'd3,
    CC_NEG    = 3'd4,
    CC_GE     = 3'd5,
    CC_LT     = 3'd6,
    CC_ALWAYS = 3'd7
  } jmp_cc_e;

  localparam logic [2:0] JMP_HDR = 3'b001;
endpackage

// File: rtl/jmp_cond_eval.sv
module jmp_cond_eval
  import jmp_pkg::*;
(
  input  logic [2:0]  hdr,
  input  logic [2:0]  cc,
  input  jmp_flags_t  flags,
  output logic        take
);
  logic cond_hit;

  always_comb begin
    unique case (jmp_cc_e'(cc))
      CC_NZERO:  cond_hit = ~flags.z;
      CC_ZERO:   cond_hit = flags.z;
      CC_NCARRY: cond_hit = ~flags.c;
      CC_CARRY:  cond_hit = flags.c;
      CC_NEG:    cond_hit = flags.n;
      CC_GE:     cond_hit = ~(flags.n ^ flags.v);
      CC_LT:     cond_hit = flags.n ^ flags.v;
      default:   cond_hit = 1'b1;
    endcase
  end

  assign take = (hdr == JMP_HDR) & cond_hit;
endmodule

// File: rtl/jmp_target_calc.sv
module jmp_target_calc #(
  parameter int ADDR_W = 16,
  parameter int OFS_W  = 10
) (
  input  logic [ADDR_W-1:0] base,
  input  logic [OFS_W-1:0]  ofs,
  output logic [ADDR_W-1:0] target
);
  localparam int EXT_W = ADDR_W - OFS_W - 1;

  logic [ADDR_W-1:0] ofs_scaled;

  generate
    if (EXT_W > 0) begin : g_ext
      assign ofs_scaled = {{EXT_W{ofs[OFS_W-1]}}, ofs, 1'b0};
    end else begin : g_trunc
      assign ofs_scaled = ADDR_W'({ofs, 1'b0});
    end
  endgenerate

  assign target = base + ofs_scaled;
endmodule

// File: rtl/jmp_out_stage.sv
module jmp_out_stage #(
  parameter int ADDR_W  = 16,
  parameter bit REG_OUT = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [ADDR_W-1:0] d_target,
  input  logic              d_taken,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [ADDR_W-1:0] out_target,
  output logic              out_taken
);
  generate
    if (REG_OUT) begin : g_reg
      logic              vld_q;
      logic [ADDR_W-1:0] tgt_q;
      logic              tkn_q;

      assign in_ready = ~vld_q | out_ready;

      always_ff @(posedge clk) begin
        if (!rst_n) begin
          vld_q <= 1'b0;
          tgt_q <= '0;
          tkn_q <= 1'b0;
        end else if (in_ready) begin
          vld_q <= in_valid;
          if (in_valid) begin
            tgt_q <= d_target;
            tkn_q <= d_taken;
          end
        end
      end

      assign out_valid  = vld_q;
      assign out_target = tgt_q;
      assign out_taken  = tkn_q;
    end else begin : g_comb
      assign in_ready   = out_ready;
      assign out_valid  = in_valid;
      assign out_target = d_target;
      assign out_taken  = d_taken;
    end
  endgenerate
endmodule

// File: rtl/jmp_resolve.sv
module jmp_resolve
  import jmp_pkg::*;
#(
  parameter int WORD_W  = 16,
  parameter int OFS_W   = 10,
  parameter bit REG_OUT = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WORD_W-1:0] instr_word,
  input  logic [WORD_W-1:0] next_pc,
  input  logic              flag_v,
  input  logic              flag_n,
  input  logic              flag_z,
  input  logic              flag_c,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [WORD_W-1:0] out_target,
  output logic              out_taken
);
  localparam int HDR_LSB = WORD_W - 3;
  localparam int CC_LSB  = HDR_LSB - 3;

  jmp_flags_t        flags;
  logic              take_c;
  logic [WORD_W-1:0] target_c;

  assign flags = '{v: flag_v, n: flag_n, z: flag_z, c: flag_c};

  jmp_cond_eval u_cond (
    .hdr   (instr_word[WORD_W-1:HDR_LSB]),
    .cc    (instr_word[HDR_LSB-1:CC_LSB]),
    .flags (flags),
    .take  (take_c)
  );

  jmp_target_calc #(.ADDR_W(WORD_W), .OFS_W(OFS_W)) u_tgt (
    .base   (next_pc),
    .ofs    (instr_word[OFS_W-1:0]),
    .target (target_c)
  );

  jmp_out_stage #(.ADDR_W(WORD_W), .REG_OUT(REG_OUT)) u_out (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .d_target   (target_c),
    .d_taken    (take_c),
    .out_valid  (out_valid),
    .out_ready  (out_ready),
    .out_target (out_target),
    .out_taken  (out_taken)
  );
endmodule

// File: rtl/jmp_resolve_chk.sv
module jmp_resolve_chk #(
  parameter int WORD_W  = 16,
  parameter bit REG_OUT = 1'b1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic [5:0]        hdr_cc,
  input logic              next_pc0,
  input logic              out_valid,
  input logic              out_ready,
  input logic [WORD_W-1:0] out_target,
  input logic              out_taken
);
  logic [5:0] seen_hdr_cc;
  logic       seen_pc0;

  generate
    if (REG_OUT) begin : g_reg
      logic [5:0] cap_hdr_cc;
      logic       cap_pc0;
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          cap_hdr_cc <= '0;
          cap_pc0    <= 1'b0;
        end else if (in_valid && in_ready) begin
          cap_hdr_cc <= hdr_cc;
          cap_pc0    <= next_pc0;
        end
      end
      assign seen_hdr_cc = cap_hdr_cc;
      assign seen_pc0    = cap_pc0;

      // R8
      a_r8_valid_next: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> out_valid);
      // R8
      a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_target) && $stable(out_taken)));
      // R9
      a_r9_stall: assert property (@(posedge clk) disable iff (!rst_n)
        !in_ready |-> (out_valid && !out_ready));
    end else begin : g_comb
      assign seen_hdr_cc = hdr_cc;
      assign seen_pc0    = next_pc0;
    end
  endgenerate

  // R7
  a_r7_nonjump_not_taken: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && seen_hdr_cc[5:3] != 3'b001) |-> !out_taken);
  // R5
  a_r5_always_taken: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && seen_hdr_cc == 6'b001111) |-> out_taken);
  // R10
  a_r10_even_target: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !seen_pc0) |-> !out_target[0]);
endmodule

bind jmp_resolve jmp_resolve_chk #(.WORD_W(WORD_W), .REG_OUT(REG_OUT)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .hdr_cc     (instr_word[WORD_W-1:WORD_W-6]),
  .next_pc0   (next_pc[0]),
  .out_valid  (out_valid),
  .out_ready  (out_ready),
  .out_target (out_target),
  .out_taken  (out_taken)
);

// File: tb/sim_jmp_resolve.sv
module sim_jmp_resolve;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [15:0] instr_word = '0;
  logic [15:0] next_pc = '0;
  logic        flag_v = 0, flag_n = 0, flag_z = 0, flag_c = 0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [15:0] out_target;
  logic        out_taken;

  int n_run  = 0;
  int n_fail = 0;
  int cyc    = 0;
  bit done   = 0;

  always #(CLK_P/2) clk = ~clk;

  jmp_resolve u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .instr_word(instr_word), .next_pc(next_pc),
    .flag_v(flag_v), .flag_n(flag_n), .flag_z(flag_z), .flag_c(flag_c),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_target(out_target), .out_taken(out_taken)
  );

  function automatic bit exp_taken(logic [15:0] w, bit v, bit n, bit z, bit c);
    if (w[15:13] != 3'b001) return 1'b0;
    case (w[12:10])
      3'd0: return !z;
      3'd1: return z;
      3'd2: return !c;
      3'd3: return c;
      3'd4: return n;
      3'd5: return n == v;
      3'd6: return n != v;
      default: return 1'b1;
    endcase
  endfunction

  function automatic logic [15:0] exp_target(logic [15:0] w, logic [15:0] np);
    logic [15:0] d;
    d = {{5{w[9]}}, w[9:0], 1'b0};
    return np + d;
  endfunction

  function automatic string taken_tag(logic [15:0] w);
    if (w[15:13] != 3'b001) return "R7";
    case (w[12:10])
      3'd0, 3'd1: return "R1";
      3'd2, 3'd3: return "R2";
      3'd4:       return "R3";
      3'd5, 3'd6: return "R4";
      default:    return "R5";
    endcase
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic drive(logic [15:0] w, logic [15:0] np, logic [3:0] f);
    instr_word = w; next_pc = np;
    {flag_v, flag_n, flag_z, flag_c} = f;
  endtask

  task automatic check_out(logic [15:0] w, logic [15:0] np, logic [3:0] f);
    logic [15:0] et;
    bit ek;
    et = exp_target(w, np);
    ek = exp_taken(w, f[3], f[2], f[1], f[0]);
    chk(out_valid === 1'b1, "R8", int'(out_valid), 1);
    chk(out_target === et, "R6", int'(out_target), int'(et));
    chk(out_taken === ek, taken_tag(w), int'(out_taken), int'(ek));
    if (!np[0]) chk(out_target[0] === 1'b0, "R10", int'(out_target[0]), 0);
  endtask

  task automatic send_one(logic [15:0] w, logic [15:0] np, logic [3:0] f, int stall);
    logic [15:0] t0;
    bit k0;
    @(negedge clk);
    drive(w, np, f);
    in_valid = 1'b1; out_ready = 1'b0;
    chk(in_ready === 1'b1, "R9", int'(in_ready), 1);
    @(negedge clk);
    in_valid = 1'b0;
    check_out(w, np, f);
    t0 = out_target; k0 = out_taken;
    for (int i = 0; i < stall; i++) begin
      drive(~w, ~np, ~f);
      @(negedge clk);
      chk(out_valid === 1'b1 && out_target === t0 && out_taken === k0, "R8",
          int'(out_target), int'(t0));
      chk(in_ready === 1'b0, "R9", int'(in_ready), 0);
    end
    out_ready = 1'b1;
    @(negedge clk);
    chk(out_valid === 1'b0, "R8", int'(out_valid), 0);
    out_ready = 1'b0;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000 && !done) begin
        done = 1;
        n_run++; n_fail++;
        $display("FAIL watchdog actual=%0d expected=<150000", cyc);
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
      end
    end
  end

  initial begin
    logic [31:0] seed;
    seed = $urandom(32'h5EED_1234);
    repeat (3) @(negedge clk);
    chk(out_valid === 1'b0, "R9", int'(out_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(out_valid === 1'b0, "R9", int'(out_valid), 0);
    chk(in_ready === 1'b1, "R9", int'(in_ready), 1);

    // R1..R5 each code with all flag combinations
    for (int cc = 0; cc < 8; cc++)
      for (int f = 0; f < 16; f++)
        send_one({3'b001, cc[2:0], 10'h005}, 16'h4000, f[3:0], 0);

    // R7 non-jump headers, flags all set, always code
    for (int h = 0; h < 8; h++)
      if (h != 1) begin
        send_one({h[2:0], 3'b111, 10'h010}, 16'h1000, 4'hF, 1);
        send_one({h[2:0], 3'b000, 10'h010}, 16'h1000, 4'h0, 0);
      end

    // R6 offset corners and wrap
    send_one({6'b001111, 10'h1FF}, 16'h8000, 4'h0, 0);
    send_one({6'b001111, 10'h200}, 16'h8000, 4'h0, 0);
    send_one({6'b001111, 10'h001}, 16'hFFFE, 4'h0, 2);
    send_one({6'b001111, 10'h3FF}, 16'h0000, 4'h0, 0);
    send_one({6'b001111, 10'h200}, 16'h0100, 4'h0, 0);
    send_one({6'b001111, 10'h000}, 16'h1234, 4'h0, 0);

    // R8 back-to-back with out_ready high
    @(negedge clk);
    out_ready = 1'b1; in_valid = 1'b1;
    drive(16'h2400 | 16'h0003, 16'h0200, 4'h0);
    @(negedge clk);
    check_out(16'h2403, 16'h0200, 4'h0);
    chk(in_ready === 1'b1, "R9", int'(in_ready), 1);
    drive(16'h2C00 | 16'h03F0, 16'h0300, 4'h0);
    @(negedge clk);
    in_valid = 1'b0;
    check_out(16'h2FF0, 16'h0300, 4'h0);
    @(negedge clk);
    chk(out_valid === 1'b0, "R8", int'(out_valid), 0);
    out_ready = 1'b0;

    // random mix
    for (int i = 0; i < 400; i++) begin
      logic [15:0] w, np;
      logic [3:0] f;
      w  = 16'($urandom);
      if ($urandom % 4 != 0) w[15:13] = 3'b001;
      np = 16'($urandom);
      if ($urandom % 2 == 0) np[0] = 1'b0;
      f  = 4'($urandom);
      send_one(w, np, f, int'($urandom % 3));
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule